// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block arbitrates four interrupt sources for a small microcontroller core. The sources are two timer/event counter overflows, a time base time-out and a real time clock time-out. Each source arrives as a one-cycle event pulse and sets a request flag. A request is taken when the flag, the source's enable and a global master enable are all set, and the core's call stack is not full. The block then raises an interrupt request toward the core together with a fixed vector address.

The request stays up until the core acknowledges it. The acknowledge clears the serviced source's flag and the master enable, so no nested interrupt is taken until software or the core's return logic sets the master enable again. Flags, enables and the master enable sit in two 8-bit control registers that software can write and read back.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, `irqReq` is 0 and `irqVector` is 0x00.
- R2: An event pulse on `srcEvent[i]` sets flag i whether or not source i is enabled. The source order is bit 0 timer 0, bit 1 timer 1, bit 2 time base, bit 3 real time clock.
- R3: A request is taken only when the master enable is 1, `stackFull` is 0, and some source has both its flag and its enable set. `irqReq` rises on the clock edge after the cycle in which these conditions hold.
- R4: The vectors are 0x0C for timer 0, 0x10 for timer 1, 0x14 for the time base and 0x18 for the real time clock.
- R5: When several enabled flags are pending, the source with the lowest vector is taken first.
- R6: `irqReq` stays 1 until `irqAck`, and `irqVector` does not change while the request is outstanding, even when a higher-priority request arrives.
- R7: An `irqAck` while `irqReq` is 1 drops `irqReq` on that edge. It also clears the serviced source's flag and the master enable, and it leaves the other flags and all enables unchanged.
- R8: An event pulse in the same cycle as a software clear of its flag, or as the service of that same source, leaves the flag set.
- R9: Register 0 holds the master enable in bit 0, the timer 0 enable in bit 1, the timer 1 enable in bit 2, the timer 0 flag in bit 5 and the timer 1 flag in bit 6. Register 1 holds the time base enable in bit 1, the RTC enable in bit 2, the time base flag in bit 5 and the RTC flag in bit 6. A write replaces all of these bits, flags included. Every other bit reads 0.
- R10: A one-cycle pulse on `masterSet` sets the master enable. An acknowledge in the same cycle takes precedence and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| srcEvent | input | 4 | One-cycle event pulses, one per source |
| stackFull | input | 1 | Core call stack is full |
| ctl0Wr | input | 1 | Write strobe for control register 0 |
| ctl0WrData | input | 8 | Write data for control register 0 |
| ctl1Wr | input | 1 | Write strobe for control register 1 |
| ctl1WrData | input | 8 | Write data for control register 1 |
| masterSet | input | 1 | Re-enable master enable (return from interrupt) |
| irqAck | input | 1 | Core acknowledges the outstanding request |
| irqReq | output | 1 | Interrupt request to the core |
| irqVector | output | 8 | Vector address of the outstanding request |
| ctl0Rd | output | 8 | Read value of control register 0 |
| ctl1Rd | output | 8 | Read value of control register 1 |

## Verification
A source's event pulse can land in the same cycle as a software write that clears its flag. It can also land in the same cycle as the acknowledge that services that very source. The bench provokes both cases by driving the event together with the register write strobe, and separately together with `irqAck`. In each case the flag must read back as set on the next cycle. In the acknowledge case the master enable must read back as cleared, so the flag survives without causing an immediate re-entry.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NUM_SRC = 4;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int REG_W   = 8;
  localparam int NUM_REG = (NUM_SRC + 1) / 2;
  localparam int VEC_W   = 8;

  typedef struct packed {
    logic             take;
    logic             svc;
    logic [IDX_W-1:0] idx;
  } ivcStrobe_t;

  typedef enum logic {ST_IDLE, ST_PEND} ivcState_e;
endpackage

// File: rtl/ivc_control.sv
module ivc_control
  import ivc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendMask,
  input  logic               masterEn,
  input  logic               stackFull,
  input  logic               irqAck,
  output ivcStrobe_t         strobe,
  output logic               irqReq
);
  ivcState_e        state;
  logic [IDX_W-1:0] winReg;
  logic [IDX_W-1:0] winIdx;
  logic             takeNow;
  logic             svcNow;

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendMask[i]) winIdx = i[IDX_W-1:0];
    end
  end

  assign takeNow = (state == ST_IDLE) && masterEn && !stackFull && (|pendMask);
  assign svcNow  = (state == ST_PEND) && irqAck;

  always_comb begin
    strobe.take = takeNow;
    strobe.svc  = svcNow;
    strobe.idx  = takeNow ? winIdx : winReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      winReg <= '0;
    end else if (takeNow) begin
      state  <= ST_PEND;
      winReg <= winIdx;
    end else if (svcNow) begin
      state  <= ST_IDLE;
    end
  end

  assign irqReq = (state == ST_PEND);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> irqReq);

  assert_ack_drops_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && irqAck) |=> !irqReq);
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath
  import ivc_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h0C,
  parameter logic [VEC_W-1:0] VEC_STEP = 8'h04
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEvent,
  input  logic [NUM_REG-1:0] regWr,
  input  logic [NUM_REG-1:0][REG_W-1:0] regData,
  input  logic               masterSet,
  input  ivcStrobe_t         strobe,
  output logic [NUM_SRC-1:0] pendMask,
  output logic               masterEn,
  output logic [VEC_W-1:0]   vector,
  output logic [NUM_REG-1:0][REG_W-1:0] regRd
);
  localparam int EN_LSB   = 1;
  localparam int FLAG_LSB = 5;

  logic [NUM_SRC-1:0] flag, flagNext;
  logic [NUM_SRC-1:0] en, enNext;
  logic               masterNext;
  logic [VEC_W-1:0]   vecNext;

  always_comb begin
    flagNext = flag;
    enNext   = en;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (regWr[i / 2]) begin
        flagNext[i] = regData[i / 2][FLAG_LSB + (i % 2)];
        enNext[i]   = regData[i / 2][EN_LSB + (i % 2)];
      end
      if (strobe.svc && (strobe.idx == i[IDX_W-1:0])) flagNext[i] = 1'b0;
      if (srcEvent[i]) flagNext[i] = 1'b1;
    end
  end

  always_comb begin
    masterNext = masterEn;
    if (regWr[0]) masterNext = regData[0][0];
    if (masterSet) masterNext = 1'b1;
    if (strobe.svc) masterNext = 1'b0;
  end

  assign vecNext = VEC_BASE + VEC_STEP * {{(VEC_W - IDX_W){1'b0}}, strobe.idx};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag     <= '0;
      en       <= '0;
      masterEn <= 1'b0;
      vector   <= '0;
    end else begin
      flag     <= flagNext;
      en       <= enNext;
      masterEn <= masterNext;
      if (strobe.take) vector <= vecNext;
    end
  end

  assign pendMask = flag & en;

  always_comb begin
    regRd       = '0;
    regRd[0][0] = masterEn;
    for (int i = 0; i < NUM_SRC; i++) begin
      regRd[i / 2][FLAG_LSB + (i % 2)] = flag[i];
      regRd[i / 2][EN_LSB + (i % 2)]   = en[i];
    end
  end

  assert_event_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|srcEvent) |=> ((flag & $past(srcEvent)) == $past(srcEvent)));

  assert_svc_clears_master_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.svc |=> !masterEn);

  assert_enables_kept_on_svc_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.svc && !(|regWr)) |=> $stable(en));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import ivc_pkg::*;
#(
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h0C,
  parameter logic [VEC_W-1:0] VEC_STEP = 8'h04
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SRC-1:0]   srcEvent,
  input  logic                 stackFull,
  input  logic                 ctl0Wr,
  input  logic [REG_W-1:0]     ctl0WrData,
  input  logic                 ctl1Wr,
  input  logic [REG_W-1:0]     ctl1WrData,
  input  logic                 masterSet,
  input  logic                 irqAck,
  output logic                 irqReq,
  output logic [VEC_W-1:0]     irqVector,
  output logic [REG_W-1:0]     ctl0Rd,
  output logic [REG_W-1:0]     ctl1Rd
);
  localparam logic [VEC_W-1:0] VEC_LAST =
    VEC_BASE + VEC_STEP * VEC_W'(NUM_SRC - 1);

  ivcStrobe_t                    strobe;
  logic [NUM_SRC-1:0]            pendMask;
  logic                          masterEn;
  logic [NUM_REG-1:0]            regWr;
  logic [NUM_REG-1:0][REG_W-1:0] regData;
  logic [NUM_REG-1:0][REG_W-1:0] regRd;

  assign regWr   = {ctl1Wr, ctl0Wr};
  assign regData = {ctl1WrData, ctl0WrData};
  assign ctl0Rd  = regRd[0];
  assign ctl1Rd  = regRd[1];

  ivc_control i_control (
    .clk       (clk),
    .rstN      (rstN),
    .pendMask  (pendMask),
    .masterEn  (masterEn),
    .stackFull (stackFull),
    .irqAck    (irqAck),
    .strobe    (strobe),
    .irqReq    (irqReq)
  );

  ivc_datapath #(
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .srcEvent  (srcEvent),
    .regWr     (regWr),
    .regData   (regData),
    .masterSet (masterSet),
    .strobe    (strobe),
    .pendMask  (pendMask),
    .masterEn  (masterEn),
    .vector    (irqVector),
    .regRd     (regRd)
  );

  assert_take_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(masterEn && !stackFull && (|pendMask)));

  assert_vec_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !irqAck) |=> $stable(irqVector));

  assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector >= VEC_BASE && irqVector <= VEC_LAST && irqVector[1:0] == 2'b00));
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/100ps
module test_irq_vector_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] srcEvent = '0;
  logic       stackFull = 1'b0;
  logic       ctl0Wr = 1'b0, ctl1Wr = 1'b0;
  logic [7:0] ctl0WrData = '0, ctl1WrData = '0;
  logic       masterSet = 1'b0, irqAck = 1'b0;
  logic       irqReq;
  logic [7:0] irqVector, ctl0Rd, ctl1Rd;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .stackFull(stackFull),
    .ctl0Wr(ctl0Wr), .ctl0WrData(ctl0WrData), .ctl1Wr(ctl1Wr), .ctl1WrData(ctl1WrData),
    .masterSet(masterSet), .irqAck(irqAck), .irqReq(irqReq), .irqVector(irqVector),
    .ctl0Rd(ctl0Rd), .ctl1Rd(ctl1Rd)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtl(input bit sel, input logic [7:0] d);
    if (sel) begin ctl1Wr = 1'b1; ctl1WrData = d; end
    else     begin ctl0Wr = 1'b1; ctl0WrData = d; end
    @(negedge clk);
    ctl0Wr = 1'b0; ctl1Wr = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] m);
    srcEvent = m;
    @(negedge clk);
    srcEvent = '0;
  endtask

  task automatic pulseMaster();
    masterSet = 1'b1;
    @(negedge clk);
    masterSet = 1'b0;
  endtask

  task automatic ack();
    irqAck = 1'b1;
    @(negedge clk);
    irqAck = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 ctl0", ctl0Rd, 8'h00);
    chk("R1 ctl1", ctl1Rd, 8'h00);
    chk("R1 irqReq", {7'd0, irqReq}, 8'h00);
    chk("R1 vector", irqVector, 8'h00);
  endtask

  task automatic tFlagWithoutEnable();
    pulse(4'h4);
    chk("R2 tb flag set while disabled", ctl1Rd, 8'h20);
    idle(1);
    chk("R3 no request without enables", {7'd0, irqReq}, 8'h00);
    wrCtl(1'b1, 8'h00);
    chk("R9 software clear of flag", ctl1Rd, 8'h00);
  endtask

  task automatic tGating();
    wrCtl(1'b0, 8'h02);
    pulse(4'h1);
    chk("R2 t0 flag", ctl0Rd, 8'h22);
    idle(1);
    chk("R3 master off blocks", {7'd0, irqReq}, 8'h00);
    stackFull = 1'b1;
    wrCtl(1'b0, 8'h23);
    idle(2);
    chk("R3 stack full blocks", {7'd0, irqReq}, 8'h00);
    stackFull = 1'b0;
    idle(1);
    chk("R3 taken when stack frees", {7'd0, irqReq}, 8'h01);
    chk("R4 timer0 vector", irqVector, 8'h0C);
    ack();
    chk("R7 ack drops request", {7'd0, irqReq}, 8'h00);
    chk("R7 flag and master cleared, enable kept", ctl0Rd, 8'h02);
  endtask

  task automatic tPriority();
    logic [7:0] expVec [4] = '{8'h0C, 8'h10, 8'h14, 8'h18};
    logic [7:0] exp0   [4] = '{8'h46, 8'h06, 8'h06, 8'h06};
    logic [7:0] exp1   [4] = '{8'h66, 8'h66, 8'h46, 8'h06};
    wrCtl(1'b0, 8'h06);
    wrCtl(1'b1, 8'h06);
    pulse(4'hF);
    chk("R2 all flags reg0", ctl0Rd, 8'h66);
    chk("R2 all flags reg1", ctl1Rd, 8'h66);
    for (int k = 0; k < 4; k++) begin
      pulseMaster();
      chk("R10 masterSet sets master", ctl0Rd & 8'h01, 8'h01);
      idle(1);
      chk("R5 request taken", {7'd0, irqReq}, 8'h01);
      chk("R5 R4 priority vector", irqVector, expVec[k]);
      ack();
      chk("R7 reg0 after service", ctl0Rd, exp0[k]);
      chk("R7 reg1 after service", ctl1Rd, exp1[k]);
    end
  endtask

  task automatic tHold();
    wrCtl(1'b0, 8'h07);
    pulse(4'h8);
    idle(1);
    chk("R4 rtc vector", irqVector, 8'h18);
    pulse(4'h1);
    idle(3);
    chk("R6 request held", {7'd0, irqReq}, 8'h01);
    chk("R6 vector stable", irqVector, 8'h18);
    ack();
    chk("R7 only rtc flag cleared reg0", ctl0Rd, 8'h26);
    chk("R7 only rtc flag cleared reg1", ctl1Rd, 8'h06);
    idle(2);
    chk("R3 no re-entry with master off", {7'd0, irqReq}, 8'h00);
    wrCtl(1'b0, 8'h06);
  endtask

  task automatic tCollide();
    pulse(4'h2);
    ctl0Wr = 1'b1; ctl0WrData = 8'h06; srcEvent = 4'h2;
    @(negedge clk);
    ctl0Wr = 1'b0; srcEvent = '0;
    chk("R8 event beats software clear", ctl0Rd, 8'h46);
    wrCtl(1'b0, 8'h06);
    chk("R9 software clear reg0", ctl0Rd, 8'h06);
    wrCtl(1'b1, 8'h66);
    chk("R9 software set reg1", ctl1Rd, 8'h66);
    chk("R3 software-set flags need master", {7'd0, irqReq}, 8'h00);
    ctl1Wr = 1'b1; ctl1WrData = 8'h06; srcEvent = 4'h4;
    @(negedge clk);
    ctl1Wr = 1'b0; srcEvent = '0;
    chk("R8 tb event beats clear", ctl1Rd, 8'h26);
    wrCtl(1'b1, 8'h06);
    pulseMaster();
    pulse(4'h8);
    idle(1);
    chk("R4 rtc vector again", irqVector, 8'h18);
    irqAck = 1'b1; srcEvent = 4'h8;
    @(negedge clk);
    irqAck = 1'b0; srcEvent = '0;
    chk("R8 event beats service clear", ctl1Rd, 8'h46);
    chk("R7 master cleared on collision", ctl0Rd, 8'h06);
    chk("R7 request dropped", {7'd0, irqReq}, 8'h00);
    wrCtl(1'b1, 8'h06);
  endtask

  task automatic tMasterAckRace();
    pulse(4'h4);
    pulseMaster();
    idle(1);
    chk("R4 time base vector", irqVector, 8'h14);
    irqAck = 1'b1; masterSet = 1'b1;
    @(negedge clk);
    irqAck = 1'b0; masterSet = 1'b0;
    chk("R10 ack beats masterSet", ctl0Rd, 8'h06);
  endtask

  task automatic tLayout();
    wrCtl(1'b0, 8'hFF);
    chk("R9 reg0 unused bits read 0", ctl0Rd, 8'h67);
    wrCtl(1'b1, 8'hFF);
    chk("R9 reg1 unused bits read 0", ctl1Rd, 8'h66);
    chk("R5 software flags taken lowest first", irqVector, 8'h0C);
    ack();
  endtask

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    tReset();
    tFlagWithoutEnable();
    tGating();
    tPriority();
    tHold();
    tCollide();
    tMasterAckRace();
    tLayout();
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule